// File: doc/BRIEF.md
# Sliding-Window Wavelet Power Trigger

This block watches one stream of signed ADC samples and decides, on every accepted sample, whether the most recent 32 samples hold enough band-limited energy to raise a trigger. It keeps all 32 complex spectral bins of the current window up to date on each accepted sample. Each bin is updated from the difference between the newest sample and the sample 32 places back. Because the spectrum is always current, the power estimate is never tied to a fixed block boundary, and no search for the best-aligned block is needed.

The power estimate is the sum over all bins of the squared bin magnitude times a per-bin gain. The gain stands for the squared magnitude of a complex wavelet weight. Several gain sets live in a constant table, and an input selects the set to apply. The estimate is compared with a programmable threshold. The bins are accumulated with integer twiddle values in an absolute-phase form. That form is exact, so rounding error cannot build up however long the stream runs.

Top module: `wpt_trigger`

## Requirements
- R1: After reset `pwr_o` is 0 and `trig_o` is 0. `pwr_o` stays 0 until an accepted sample has had time to reach it.
- R2: Number the accepted samples 0, 1, 2 … from reset, and let n be each sample's number modulo 32. Take the integer table C[m] = 1024, 1004, 946, 851, 724, 569, 392, 200, 0 for m = 0..8. Extend it with C[16−m] = −C[m] and C[32−m] = C[m], and set S[m] = C[(m+24) mod 32]. For each bin k in 0..31, Re_k = Σ x·C[(k·n) mod 32] and Im_k = −Σ x·S[(k·n) mod 32], both taken over the 32 newest accepted samples. The power is Σ_k G[sel][k]·(Re_k² + Im_k²), with no rounding.
- R3: The power at `pwr_o` is computed from the bins as they stood before the most recent clock edge, using the `wv_sel` value sampled at that edge. A sample accepted at edge E therefore first shows in `pwr_o` after edge E+1.
- R4: A cycle with `smp_valid` low changes no bin. The sample value on that cycle never enters the window.
- R5: A sample leaves the window after 32 further accepted samples. From then on it contributes nothing to the power.
- R6: `trig_o` is high for one cycle after edge E+1 exactly when a sample was accepted at edge E and the power shown after E+1 is greater than or equal to `thr_i` as sampled at E+1.
- R7: `trig_o` stays low until 32 samples have been accepted since reset.
- R8: The gain G[s][k] is computed as follows. Let f = min(k, 32−k), c = 3+4s and d = |f−c|. Then G[s][k] = 4−d when d < 4, and 0 otherwise. `wv_sel` picks s.
- R9: A window full of full-scale samples (−2048 or +2047) produces the exact R2 power, with no wrap in the bins or in the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMP_W (12) | Signed sample |
| thr_i | input | PWR_W (64) | Trigger threshold, unsigned |
| wv_sel | input | SEL_W (2) | Gain set select |
| pwr_o | output | PWR_W (64) | Weighted power estimate |
| trig_o | output | 1 | Trigger pulse |

## Verification
Three things can happen at the same clock edge: a new sample folds into the bins, the power of the window as it stood before is registered, and the trigger for the sample before is decided. The bench drives back-to-back accepted samples with the threshold set equal to the expected power, to zero and to one above it. It also changes `wv_sel` in the same cycle as a sample, so the edge must use the old bins with the new gain set. Each output is checked one cycle after its edge against a reference that recomputes the R2 sums over the bench's own copy of the window.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
    localparam int DFT_N  = 32;
    localparam int IDX_W  = $clog2(DFT_N);
    localparam int TW_W   = 12;
    localparam int GAIN_W = 3;

    // first quadrant of the cosine table, scale 1024
    function automatic logic signed [TW_W-1:0] quad_cos(input int m);
        case (m)
            0: return 12'sd1024;
            1: return 12'sd1004;
            2: return 12'sd946;
            3: return 12'sd851;
            4: return 12'sd724;
            5: return 12'sd569;
            6: return 12'sd392;
            7: return 12'sd200;
            default: return 12'sd0;
        endcase
    endfunction

    function automatic logic signed [TW_W-1:0] tw_cos(input int m);
        int r;
        r = m % DFT_N;
        if (r <= DFT_N/4)        return quad_cos(r);
        else if (r <= DFT_N/2)   return -quad_cos(DFT_N/2 - r);
        else if (r <= 3*DFT_N/4) return -quad_cos(r - DFT_N/2);
        else                     return quad_cos(DFT_N - r);
    endfunction

    function automatic logic signed [TW_W-1:0] tw_sin(input int m);
        return tw_cos(m + 3*DFT_N/4);
    endfunction

    // squared wavelet weight per bin and set
    function automatic logic [GAIN_W-1:0] wv_gain(input int set, input int k);
        int f, c, d;
        f = (k <= DFT_N/2) ? k : DFT_N - k;
        c = 3 + 4*set;
        d = (f > c) ? f - c : c - f;
        return (d >= 4) ? '0 : GAIN_W'(4 - d);
    endfunction
endpackage

// File: rtl/wpt_bin.sv
module wpt_bin
    import wpt_pkg::*;
#(
    parameter int K      = 0,
    parameter int SAMP_W = 12,
    parameter int ACC_W  = 28
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd_i,
    input  logic signed [SAMP_W:0]  delta_i,
    input  logic [IDX_W-1:0]        phase_i,
    output logic signed [ACC_W-1:0] re_o,
    output logic signed [ACC_W-1:0] im_o
);
    localparam int PROD_W = SAMP_W + TW_W + 1;

    typedef struct packed {
        logic signed [ACC_W-1:0] re;
        logic signed [ACC_W-1:0] im;
    } bin_t;

    bin_t bin_d, bin_q;
    logic [IDX_W-1:0]         idx;
    logic signed [TW_W-1:0]   c_tw, s_tw;
    logic signed [PROD_W-1:0] p_re, p_im;

    always_comb begin
        idx   = phase_i * IDX_W'(K);
        c_tw  = tw_cos(int'(idx));
        s_tw  = tw_sin(int'(idx));
        p_re  = delta_i * c_tw;
        p_im  = delta_i * s_tw;
        bin_d = bin_q;
        if (upd_i) begin
            bin_d.re = bin_q.re + ACC_W'(p_re);
            bin_d.im = bin_q.im - ACC_W'(p_im);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bin_q <= '0;
        else        bin_q <= bin_d;
    end

    assign re_o = bin_q.re;
    assign im_o = bin_q.im;
endmodule

// File: rtl/wpt_power.sv
module wpt_power
    import wpt_pkg::*;
#(
    parameter int NSETS = 4,
    parameter int SEL_W = 2,
    parameter int ACC_W = 28,
    parameter int PWR_W = 64
) (
    input  logic signed [ACC_W-1:0] re_i [DFT_N],
    input  logic signed [ACC_W-1:0] im_i [DFT_N],
    input  logic [SEL_W-1:0]        sel_i,
    output logic [PWR_W-1:0]        pwr_o
);
    logic [PWR_W-1:0] term [DFT_N];

    for (genvar k = 0; k < DFT_N; k++) begin : g_bin
        logic signed [2*ACC_W-1:0] sq_re, sq_im;
        logic [2*ACC_W:0]          mag2;
        logic [GAIN_W-1:0]         g;
        always_comb begin
            sq_re = re_i[k] * re_i[k];
            sq_im = im_i[k] * im_i[k];
            mag2  = $unsigned(sq_re) + $unsigned(sq_im);
            g     = '0;
            for (int s = 0; s < NSETS; s++)
                if (int'(sel_i) == s) g = wv_gain(s, k);
            term[k] = PWR_W'(mag2) * PWR_W'(g);
        end
    end

    always_comb begin
        pwr_o = '0;
        for (int k = 0; k < DFT_N; k++) pwr_o = pwr_o + term[k];
    end
endmodule

// File: rtl/wpt_trigger.sv
module wpt_trigger
    import wpt_pkg::*;
#(
    parameter int SAMP_W = 12,
    parameter int NSETS  = 4,
    parameter int SEL_W  = (NSETS > 1) ? $clog2(NSETS) : 1,
    parameter int ACC_W  = SAMP_W + TW_W + IDX_W - 1,
    parameter int PWR_W  = 2*ACC_W + GAIN_W + IDX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic signed [SAMP_W-1:0] smp_data,
    input  logic [PWR_W-1:0]         thr_i,
    input  logic [SEL_W-1:0]         wv_sel,
    output logic [PWR_W-1:0]         pwr_o,
    output logic                     trig_o
);
    typedef struct packed {
        logic [DFT_N-1:0][SAMP_W-1:0] win;
        logic [IDX_W-1:0]             ph;
        logic [IDX_W:0]               cnt;
        logic                         upd;
        logic [PWR_W-1:0]             pwr;
        logic                         trig;
    } st_t;

    st_t st_d, st_q;

    logic signed [SAMP_W:0]  delta;
    logic signed [ACC_W-1:0] re_w [DFT_N];
    logic signed [ACC_W-1:0] im_w [DFT_N];
    logic [PWR_W-1:0]        pwr_now;
    logic                    full;

    always_comb begin
        delta = {smp_data[SAMP_W-1], smp_data}
              - {st_q.win[DFT_N-1][SAMP_W-1], st_q.win[DFT_N-1]};
    end

    for (genvar k = 0; k < DFT_N; k++) begin : g_bins
        wpt_bin #(.K(k), .SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_bin (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_i   (smp_valid),
            .delta_i (delta),
            .phase_i (st_q.ph),
            .re_o    (re_w[k]),
            .im_o    (im_w[k])
        );
    end

    wpt_power #(.NSETS(NSETS), .SEL_W(SEL_W), .ACC_W(ACC_W), .PWR_W(PWR_W)) u_pwr (
        .re_i  (re_w),
        .im_i  (im_w),
        .sel_i (wv_sel),
        .pwr_o (pwr_now)
    );

    assign full = (st_q.cnt == (IDX_W+1)'(DFT_N));

    always_comb begin
        st_d      = st_q;
        st_d.upd  = smp_valid;
        st_d.pwr  = pwr_now;
        st_d.trig = st_q.upd && full && (pwr_now >= thr_i);
        if (smp_valid) begin
            st_d.win = {st_q.win[DFT_N-2:0], smp_data};
            st_d.ph  = st_q.ph + 1'b1;
            if (!full) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwr_o  = st_q.pwr;
    assign trig_o = st_q.trig;
endmodule

// File: rtl/wpt_trigger_chk.sv
module wpt_trigger_chk
    import wpt_pkg::*;
#(
    parameter int PWR_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_valid,
    input logic [PWR_W-1:0] thr_i,
    input logic [PWR_W-1:0] pwr_o,
    input logic             trig_o
);
    logic [IDX_W:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else if (smp_valid && int'(seen_q) < DFT_N) seen_q <= seen_q + 1'b1;
    end

    // R1
    quiet_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q == '0) |-> (pwr_o == '0 && !trig_o));

    // R7
    fill_before_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (int'(seen_q) == DFT_N));

    // R6
    trig_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $past(smp_valid, 2));

    // R6
    trig_meets_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (pwr_o >= $past(thr_i)));
endmodule

bind wpt_trigger wpt_trigger_chk #(.PWR_W(PWR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .thr_i     (thr_i),
    .pwr_o     (pwr_o),
    .trig_o    (trig_o)
);

// File: tb/wpt_trigger_test.sv
module wpt_trigger_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // kind, amplitude, repeat, valid, set, threshold mode
    // kind: 0 const, 1 alternate, 3 square period 8, 4 ramp
    // mode: 0 max, 1 zero, 2 equal to expected, 3 expected plus one
    localparam int VEC [NV][6] = '{
        '{1,   500, 40, 1, 3, 1},
        '{3,   300, 40, 1, 0, 2},
        '{3,   300,  6, 1, 2, 0},
        '{0, -2048, 36, 1, 0, 2},
        '{1,  2047, 20, 1, 3, 1},
        '{4,    37, 34, 1, 1, 2},
        '{0,    99,  3, 0, 1, 1},
        '{3, -1500, 12, 1, 2, 3}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        smp_valid = 0;
    logic signed [11:0] smp_data = '0;
    logic [63:0] thr_i = '1;
    logic [1:0]  wv_sel = '0;
    logic [63:0] pwr_o;
    logic        trig_o;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    int m_buf [32];
    int m_ph = 0, m_cnt = 0;
    bit m_upd = 0;

    wpt_trigger uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .thr_i(thr_i), .wv_sel(wv_sel), .pwr_o(pwr_o), .trig_o(trig_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint ref_cos(input int m);
        int q [9] = '{1024, 1004, 946, 851, 724, 569, 392, 200, 0};
        int r = m % 32;
        if (r <= 8)  return q[r];
        if (r <= 16) return -q[16-r];
        if (r <= 24) return -q[r-16];
        return q[32-r];
    endfunction

    function automatic longint ref_gain(input int s, input int k);
        int f = (k <= 16) ? k : 32 - k;
        int d = f - (3 + 4*s);
        if (d < 0) d = -d;
        return (d < 4) ? 4 - d : 0;
    endfunction

    function automatic longint unsigned ref_power(input int s);
        longint unsigned acc = 0;
        for (int k = 0; k < 32; k++) begin
            longint re = 0, im = 0;
            for (int n = 0; n < 32; n++) begin
                re += m_buf[n] * ref_cos(k*n);
                im -= m_buf[n] * ref_cos(k*n + 24);
            end
            acc += longint'(ref_gain(s, k)) * longint'(re*re + im*im);
        end
        return acc;
    endfunction

    task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check after the following edge
    task automatic step(input bit v, input int x, input int s, input int mode,
                        input string ptag, input string ttag);
        longint unsigned ep;
        logic [63:0] th;
        bit et;
        ep = ref_power(s);
        case (mode)
            0: th = '1;
            1: th = '0;
            2: th = ep;
            default: th = ep + 1;
        endcase
        et = m_upd && (m_cnt >= 32) && (ep >= th);
        smp_valid = v; smp_data = 12'(x); wv_sel = 2'(s); thr_i = th;
        if (v) begin
            m_buf[m_ph] = x;
            m_ph = (m_ph + 1) % 32;
            if (m_cnt < 32) m_cnt++;
        end
        m_upd = v;
        @(posedge clk);
        @(negedge clk);
        check(ptag, pwr_o, ep);
        check(ttag, 64'(trig_o), 64'(et));
    endtask

    function automatic int pattern(input int kind, input int amp, input int i);
        case (kind)
            0: return amp;
            1: return (i % 2) ? -amp : amp;
            3: return ((i / 4) % 2) ? -amp : amp;
            default: return amp * (i % 16) - 8 * amp;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_buf[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 power", pwr_o, 0);
        check("R1 trig", 64'(trig_o), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 idle", pwr_o, 0);

        // R3: impulse shows one edge late; R7: no trigger before fill
        step(1, 1000, 0, 1, "R3", "R7");
        step(1, 0, 0, 1, "R3", "R7");
        check("R3 nonzero", 64'(pwr_o != 0), 1);
        for (int i = 0; i < 30; i++) step(1, 0, 0, 1, "R2", "R7");
        // 33rd sample drops the impulse; first trigger appears after it
        step(1, 0, 0, 1, "R2", "R7");
        check("R7 first trig", 64'(trig_o), 1);
        step(0, 0, 0, 1, "R5", "R6");
        check("R5 impulse gone", pwr_o, 0);

        // R4: invalid cycles with a large value leave nothing behind
        for (int i = 0; i < 5; i++) step(0, 777, 0, 1, "R4", "R4");
        step(1, 5, 1, 0, "R4", "R6");
        step(0, 0, 1, 0, "R4", "R6");
        check("R4 window", pwr_o, ref_power(1));

        // R2 / R6 / R8: table walk
        for (int e = 0; e < NV; e++)
            for (int i = 0; i < VEC[e][2]; i++)
                step(VEC[e][3] != 0, pattern(VEC[e][0], VEC[e][1], i),
                     VEC[e][4], VEC[e][5], "R2", "R6");

        // R6: threshold equal triggers, one above does not
        step(1, 123, 2, 2, "R6", "R6");
        step(1, -321, 2, 2, "R6", "R6");
        check("R6 equal", 64'(trig_o), 1);
        step(1, 444, 2, 3, "R6", "R6");
        check("R6 above", 64'(trig_o), 0);

        // R8: set changes with a sample on the same edge, then alone
        step(1, 800, 3, 1, "R8", "R6");
        for (int s = 0; s < 4; s++) step(0, 0, s, 1, "R8", "R6");

        // R9: full-scale windows
        for (int i = 0; i < 33; i++) step(1, -2048, 0, 2, "R9", "R6");
        for (int i = 0; i < 33; i++) step(1, (i % 2) ? -2048 : 2047, 3, 2, "R9", "R6");
        step(0, 0, 0, 0, "R9", "R6");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule